// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Write Trap

This block caches recent translations from virtual page number to physical page number in a small fully associative store. Each cycle a requester may present a 32-bit virtual address with a read/write flag. In the same cycle the block answers with exactly one of three outcomes:

- **hit**: it returns the 26-bit physical address, built from the stored physical page number and the untouched page offset.
- **miss**: no valid entry holds the page, and an outside table walker must supply a refill before the access is retried.
- **trap**: the entry is present but its write permission is still closed, and the access is a write.

Write permission is kept per entry as a write-enable flag, and refill always leaves that flag cleared. The first write to a freshly loaded page therefore traps. The trap handler records the dirty state in the page tables, then issues an open-write command so that later writes translate. The buffer never holds a dirty flag of its own.

Besides lookup, the block accepts three maintenance commands, each taking one cycle:

- **refill**: writes a translation into the store.
- **invalidate**: removes a page, for use after the page tables change.
- **open-write**: sets the write-enable flag of a resident page.

A refill goes to a free slot if one exists. Otherwise it replaces the least recently used translation.

Top module: `tlb_wtrap`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports miss.
- R2: A read lookup, or a write lookup to a page whose write-enable flag is set, reports hit in the same cycle. Its physical address is {stored physical page number, vaddr[11:0]}, where the page number is vaddr[31:12].
- R3: A lookup whose page number matches no valid entry reports miss, with hit and trap low and the physical address zero.
- R4: A refill of page P with physical page Q makes a read of P in the next cycle hit with address bits [25:12] equal to Q.
- R5: A write lookup to a resident page whose write-enable flag is clear reports trap, with hit low and the physical address zero. A refilled entry starts with its flag clear.
- R6: An open-write command for a resident page sets its flag, so writes to that page hit from the next cycle. An open-write for a page not resident changes nothing.
- R7: An invalidate command removes the matching page, so it misses from the next cycle. Other resident pages are unaffected.
- R8: A refill uses a free slot while one exists. ENTRIES distinct pages can therefore be resident together, and a refill after an invalidate evicts nothing.
- R9: When every slot is valid, a refill of a non-resident page replaces the entry whose last use is oldest. A use is a refill or a lookup that reports hit; a trap does not count as a use.
- R10: A refill of a page that is already resident overwrites that entry in place. It updates the physical page, clears the write-enable flag, and evicts no other page.
- R11: At most one command acts per cycle, in the priority order refill, then invalidate, then open-write. A lower-priority command asserted in the same cycle is ignored. A lookup hit in a cycle with a refill does not count as a use.
- R12: With a lookup presented, exactly one of hit, miss and trap is high. Without one, all three are low and the physical address is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup presented this cycle |
| req_write | input | 1 | Lookup is a write |
| req_vaddr | input | 32 | Virtual address |
| rsp_hit | output | 1 | Translation delivered |
| rsp_miss | output | 1 | No resident translation, walk needed |
| rsp_trap | output | 1 | Write to page with closed write permission |
| rsp_paddr | output | 26 | Physical address on hit, else zero |
| fill_valid | input | 1 | Refill command |
| fill_vpn | input | 20 | Page number to load |
| fill_ppn | input | 14 | Physical page number to load |
| inval_valid | input | 1 | Invalidate command |
| inval_vpn | input | 20 | Page number to remove |
| wopen_valid | input | 1 | Open-write command |
| wopen_vpn | input | 20 | Page number whose write permission opens |

## Verification
The bench builds the block with its default parameters: eight entries, a 32-bit virtual address and a 26-bit physical address. Random traffic draws page numbers from a pool of twelve, larger than the store. This keeps the store full most of the time, so least-recently-used eviction, in-place refill of resident pages and free-slot reuse after invalidation all occur often. The same traffic mixes same-cycle command collisions and lookup-with-refill cycles, which exercise the priority and use-counting rules.

// File: rtl/tlb_wtrap_pkg.sv
package tlb_wtrap_pkg;

    // Maintenance action selected for a cycle, in priority order.
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_FILL  = 2'd1,
        ACT_INVAL = 2'd2,
        ACT_OPEN  = 2'd3
    } tlb_act_e;

    function automatic tlb_act_e pick_action(input logic fill, input logic inval, input logic wopen);
        if (fill)       return ACT_FILL;
        else if (inval) return ACT_INVAL;
        else if (wopen) return ACT_OPEN;
        else            return ACT_NONE;
    endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int N     = 8,
    parameter int KEY_W = 20,
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              valid,
    input  logic [N-1:0][KEY_W-1:0]   keys,
    input  logic [KEY_W-1:0]          probe,
    output logic [N-1:0]              match,
    output logic                      any,
    output logic [IW-1:0]             idx
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (keys[g] == probe);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) idx = idx | IW'(i);
        end
    end

    assign any = |match;

    // R10: a page is never resident in two slots
    a_r10_unique_match: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match));

endmodule

// File: rtl/tlb_age.sv
module tlb_age #(
    parameter int N   = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0][IW-1:0]  age_q,
    input  logic                  touch_en,
    input  logic [IW-1:0]         touch_idx,
    output logic [N-1:0][IW-1:0]  age_d,
    output logic [IW-1:0]         lru_idx
);

    logic [N-1:0] is_oldest;

    always_comb begin
        age_d = age_q;
        if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx)
                    age_d[i] = '0;
                else if (age_q[i] < age_q[touch_idx])
                    age_d[i] = age_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < N; i++) begin
            is_oldest[i] = (age_q[i] == IW'(N - 1));
            if (is_oldest[i]) lru_idx = IW'(i);
        end
    end

    // R9: ages stay a permutation, so exactly one slot is the oldest
    a_r9_single_oldest: assert property (@(posedge clk) disable iff (!rst_n) $countones(is_oldest) == 1);

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N   = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   valid,
    input  logic [IW-1:0]  lru_idx,
    output logic [IW-1:0]  victim
);

    logic          free_found;
    logic [IW-1:0] free_idx;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_found = 1'b1;
                free_idx   = IW'(i);
            end
        end
        victim = free_found ? free_idx : lru_idx;
    end

    // R8: while a slot is free, no valid entry is chosen
    a_r8_free_first: assert property (@(posedge clk) disable iff (!rst_n) (!(&valid)) |-> !valid[victim]);

endmodule

// File: rtl/tlb_wtrap.sv
module tlb_wtrap
    import tlb_wtrap_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VA_W    = 32,
    parameter int PA_W    = 26,
    parameter int OFF_W   = 12,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PPN_W  = PA_W - OFF_W,
    localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_trap,
    output logic [PA_W-1:0]   rsp_paddr,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              inval_valid,
    input  logic [VPN_W-1:0]  inval_vpn,
    input  logic              wopen_valid,
    input  logic [VPN_W-1:0]  wopen_vpn
);

    typedef struct packed {
        logic              valid;
        logic              wen;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
    } slot_t;

    typedef struct packed {
        slot_t [ENTRIES-1:0]           slot;
        logic  [ENTRIES-1:0][IW-1:0]   age;
    } state_t;

    state_t state_d, state_q;

    logic [ENTRIES-1:0]             v_vec;
    logic [ENTRIES-1:0][VPN_W-1:0]  key_vec;
    logic [ENTRIES-1:0][IW-1:0]     age_next;
    logic [IW-1:0]                  lru_idx, victim;
    logic                           touch_en;
    logic [IW-1:0]                  touch_idx;
    tlb_act_e                       act;

    logic [VPN_W-1:0]  req_vpn;
    logic [OFF_W-1:0]  req_off;
    assign req_vpn = req_vaddr[VA_W-1:OFF_W];
    assign req_off = req_vaddr[OFF_W-1:0];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            v_vec[i]   = state_q.slot[i].valid;
            key_vec[i] = state_q.slot[i].vpn;
        end
    end

    // Four parallel probes: lookup, refill, invalidate, open-write
    localparam int NPROBE = 4;
    logic [NPROBE-1:0][VPN_W-1:0]    probe_key;
    logic [NPROBE-1:0][ENTRIES-1:0]  probe_match;
    logic [NPROBE-1:0]               probe_any;
    logic [NPROBE-1:0][IW-1:0]       probe_idx;

    assign probe_key[0] = req_vpn;
    assign probe_key[1] = fill_vpn;
    assign probe_key[2] = inval_vpn;
    assign probe_key[3] = wopen_vpn;

    for (genvar p = 0; p < NPROBE; p++) begin : g_probe
        tlb_cam #(.N(ENTRIES), .KEY_W(VPN_W)) cam_i (
            .clk   (clk),
            .rst_n (rst_n),
            .valid (v_vec),
            .keys  (key_vec),
            .probe (probe_key[p]),
            .match (probe_match[p]),
            .any   (probe_any[p]),
            .idx   (probe_idx[p])
        );
    end

    tlb_age #(.N(ENTRIES)) age_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .age_q     (state_q.age),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .age_d     (age_next),
        .lru_idx   (lru_idx)
    );

    tlb_victim #(.N(ENTRIES)) victim_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (v_vec),
        .lru_idx (lru_idx),
        .victim  (victim)
    );

    // Lookup response, same cycle
    logic lk_wen;
    assign lk_wen = state_q.slot[probe_idx[0]].wen;

    always_comb begin
        rsp_hit   = req_valid && probe_any[0] && (!req_write || lk_wen);
        rsp_trap  = req_valid && probe_any[0] && req_write && !lk_wen;
        rsp_miss  = req_valid && !probe_any[0];
        rsp_paddr = rsp_hit ? {state_q.slot[probe_idx[0]].ppn, req_off} : '0;
    end

    // Next-state computation
    logic [IW-1:0] fill_slot;
    assign act       = pick_action(fill_valid, inval_valid, wopen_valid);
    assign fill_slot = probe_any[1] ? probe_idx[1] : victim;

    always_comb begin
        touch_en  = 1'b0;
        touch_idx = '0;
        if (act == ACT_FILL) begin
            touch_en  = 1'b1;
            touch_idx = fill_slot;
        end else if (rsp_hit) begin
            touch_en  = 1'b1;
            touch_idx = probe_idx[0];
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (act)
            ACT_FILL: begin
                state_d.slot[fill_slot].valid = 1'b1;
                state_d.slot[fill_slot].wen   = 1'b0;
                state_d.slot[fill_slot].vpn   = fill_vpn;
                state_d.slot[fill_slot].ppn   = fill_ppn;
            end
            ACT_INVAL: begin
                if (probe_any[2]) state_d.slot[probe_idx[2]].valid = 1'b0;
            end
            ACT_OPEN: begin
                if (probe_any[3]) state_d.slot[probe_idx[3]].wen = 1'b1;
            end
            default: ;
        endcase
        state_d.age = age_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                state_q.slot[i] <= '0;
                state_q.age[i]  <= IW'(i);
            end
        end else begin
            state_q <= state_d;
        end
    end

    // R12: exactly one outcome per lookup
    a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $countones({rsp_hit, rsp_miss, rsp_trap}) == 1);
    // R12: quiet when idle
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!rsp_hit && !rsp_miss && !rsp_trap && rsp_paddr == '0));
    // R2: offset passes through unchanged
    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_paddr[OFF_W-1:0] == req_off);
    // R4: a refilled page reads back next cycle
    a_r4_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && $past(fill_valid) && req_vpn == $past(fill_vpn))
        |-> (rsp_hit && rsp_paddr[PA_W-1:OFF_W] == $past(fill_ppn)));
    // R5: a freshly refilled page traps on write
    a_r5_fresh_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && $past(fill_valid) && req_vpn == $past(fill_vpn)) |-> rsp_trap);
    // R7: an invalidated page misses next cycle
    a_r7_inval_gone: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(inval_valid && !fill_valid) && req_vpn == $past(inval_vpn)) |-> rsp_miss);
    // R6: an open-write of a resident page lets the next write through
    a_r6_open_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && $past(wopen_valid && !fill_valid && !inval_valid && probe_any[3])
         && req_vpn == $past(wopen_vpn)) |-> rsp_hit);

endmodule

// File: tb/tlb_wtrap_tb_top.sv
`timescale 1ns/1ps
module tlb_wtrap_tb_top;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        rsp_hit, rsp_miss, rsp_trap;
    logic [25:0] rsp_paddr;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [13:0] fill_ppn = '0;
    logic        inval_valid = 1'b0;
    logic [19:0] inval_vpn = '0;
    logic        wopen_valid = 1'b0;
    logic [19:0] wopen_vpn = '0;

    always #2 clk = ~clk;

    tlb_wtrap dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_trap(rsp_trap), .rsp_paddr(rsp_paddr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .inval_valid(inval_valid), .inval_vpn(inval_vpn),
        .wopen_valid(wopen_valid), .wopen_vpn(wopen_vpn)
    );

    // Reference model: slots with last-use timestamps
    logic        m_v   [N];
    logic        m_wen [N];
    logic [19:0] m_vpn [N];
    logic [13:0] m_ppn [N];
    int          m_ts  [N];
    int          now = 0;

    int nchk = 0, nfail = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int find(input logic [19:0] vpn);
        for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) return i;
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_wen[i] = 0; m_vpn[i] = '0; m_ppn[i] = '0; m_ts[i] = 0;
        end
    endtask

    task automatic clear_in();
        req_valid = 0; req_write = 0; req_vaddr = '0;
        fill_valid = 0; inval_valid = 0; wopen_valid = 0;
    endtask

    // Inputs are set by the caller after a falling edge.
    task automatic step(input string ctx);
        int  k;
        logic eh, em, et;
        logic [25:0] ep;
        #1;
        k  = find(req_vaddr[31:12]);
        eh = req_valid && k >= 0 && (!req_write || m_wen[k]);
        et = req_valid && k >= 0 && req_write && !m_wen[k];
        em = req_valid && k < 0;
        ep = eh ? {m_ppn[k], req_vaddr[11:0]} : '0;
        if (!req_valid) begin
            chk("R12", {ctx, " idle outcome"}, {rsp_hit, rsp_miss, rsp_trap}, 3'b000);
        end else if (em) begin
            chk("R3", {ctx, " miss"}, {rsp_hit, rsp_miss, rsp_trap}, {eh, em, et});
        end else if (et) begin
            chk("R5", {ctx, " trap"}, {rsp_hit, rsp_miss, rsp_trap}, {eh, em, et});
        end else begin
            chk("R2", {ctx, " hit"}, {rsp_hit, rsp_miss, rsp_trap}, {eh, em, et});
        end
        chk("R2", {ctx, " paddr"}, rsp_paddr, ep);
        @(posedge clk);
        now++;
        if (fill_valid) begin
            int s;
            s = find(fill_vpn);
            if (s < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) s = i;
            if (s < 0) begin
                s = 0;
                for (int i = 1; i < N; i++) if (m_ts[i] < m_ts[s]) s = i;
            end
            m_v[s] = 1; m_wen[s] = 0; m_vpn[s] = fill_vpn; m_ppn[s] = fill_ppn; m_ts[s] = now;
        end else begin
            if (eh) m_ts[k] = now;
            if (inval_valid) begin
                int s; s = find(inval_vpn);
                if (s >= 0) m_v[s] = 0;
            end else if (wopen_valid) begin
                int s; s = find(wopen_vpn);
                if (s >= 0) m_wen[s] = 1;
            end
        end
        @(negedge clk);
        clear_in();
    endtask

    task automatic do_fill(input logic [19:0] vpn, input logic [13:0] ppn, input string ctx);
        fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn; step(ctx);
    endtask

    task automatic do_look(input logic [19:0] vpn, input logic wr, input string ctx);
        req_valid = 1; req_write = wr; req_vaddr = {vpn, 12'(vpn * 7 + 3)}; step(ctx);
    endtask

    // Direct observation: lookup and return outcome bits {hit,miss,trap}
    task automatic probe(input logic [19:0] vpn, input logic wr, output logic [2:0] o, output logic [13:0] pp);
        req_valid = 1; req_write = wr; req_vaddr = {vpn, 12'h5a5};
        #1;
        o  = {rsp_hit, rsp_miss, rsp_trap};
        pp = rsp_paddr[25:12];
        step("probe");
    endtask

    localparam logic [19:0] BASE = 20'h10000;

    initial begin
        logic [2:0]  o;
        logic [13:0] pp;
        void'($urandom(32'h2f6a_91c3));
        model_reset();
        clear_in();
        #1;
        // R1: during reset, lookups miss
        req_valid = 1; req_vaddr = 32'h0abc_d123;
        #1;
        chk("R1", "reset lookup", {rsp_hit, rsp_miss, rsp_trap}, 3'b010);
        req_valid = 0;
        #1;
        chk("R12", "reset idle", {rsp_hit, rsp_miss, rsp_trap, rsp_paddr}, '0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        do_look(20'h00000, 0, "R1 after reset");

        // R8: eight distinct pages all resident
        for (int i = 0; i < N; i++) do_fill(BASE + 20'(i), 14'(16'h100 + i), "R8 fill");
        for (int i = 0; i < N; i++) begin
            probe(BASE + 20'(i), 0, o, pp);
            chk("R8", "resident read", {o, pp}, {3'b100, 14'(16'h100 + i)});
        end
        // R4/R5: fresh entry traps on write
        probe(BASE, 1, o, pp);
        chk("R5", "fresh write", o, 3'b001);
        // R6: open-write, then write hits
        wopen_valid = 1; wopen_vpn = BASE; step("R6 open");
        probe(BASE, 1, o, pp);
        chk("R6", "write after open", o, 3'b100);
        // R6: open-write of absent page has no effect
        wopen_valid = 1; wopen_vpn = 20'h7777; step("R6 absent open");
        probe(20'h7777, 1, o, pp);
        chk("R6", "absent stays absent", o, 3'b010);
        // R9: oldest use now BASE+1 -> evicted by new page
        do_fill(BASE + 20'd8, 14'h3ff, "R9 fill");
        probe(BASE + 20'd1, 0, o, pp);
        chk("R9", "lru evicted", o, 3'b010);
        probe(BASE, 0, o, pp);
        chk("R9", "recent kept", o, 3'b100);
        // R10: refill resident page in place
        do_fill(BASE + 20'd2, 14'h2aa, "R10 refill");
        probe(BASE + 20'd2, 0, o, pp);
        chk("R10", "new ppn", {o, pp}, {3'b100, 14'h2aa});
        probe(BASE + 20'd2, 1, o, pp);
        chk("R10", "flag cleared", o, 3'b001);
        probe(BASE + 20'd3, 0, o, pp);
        chk("R10", "no eviction", o, 3'b100);
        // R7: invalidate one page, neighbour stays
        inval_valid = 1; inval_vpn = BASE + 20'd4; step("R7 inval");
        probe(BASE + 20'd4, 0, o, pp);
        chk("R7", "removed", o, 3'b010);
        probe(BASE + 20'd5, 0, o, pp);
        chk("R7", "neighbour kept", o, 3'b100);
        // R8: refill after invalidate evicts nothing
        do_fill(BASE + 20'd9, 14'h111, "R8 reuse");
        for (int v = 0; v < 10; v++) begin
            if (v == 1 || v == 4) continue;
            probe(BASE + 20'(v), 0, o, pp);
            chk("R8", "all resident", o, 3'b100);
        end
        // R11: refill wins over open-write in the same cycle
        fill_valid = 1; fill_vpn = BASE + 20'd5; fill_ppn = 14'h55;
        wopen_valid = 1; wopen_vpn = BASE + 20'd5; step("R11 fill+open");
        probe(BASE + 20'd5, 1, o, pp);
        chk("R11", "open ignored", o, 3'b001);
        // R11: refill wins over invalidate
        fill_valid = 1; fill_vpn = BASE + 20'd6; fill_ppn = 14'h66;
        inval_valid = 1; inval_vpn = BASE + 20'd6; step("R11 fill+inval");
        probe(BASE + 20'd6, 0, o, pp);
        chk("R11", "inval ignored", {o, pp}, {3'b100, 14'h66});
        // R11: invalidate wins over open-write
        inval_valid = 1; inval_vpn = BASE + 20'd7;
        wopen_valid = 1; wopen_vpn = BASE + 20'd3; step("R11 inval+open");
        probe(BASE + 20'd3, 1, o, pp);
        chk("R11", "open dropped", o, 3'b001);

        // Random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            req_valid = ($urandom_range(0, 9) < 8);
            req_write = $urandom_range(0, 1);
            req_vaddr = {BASE + 20'($urandom_range(0, 11)), 12'($urandom)};
            if (r < 20) begin
                fill_valid = 1; fill_vpn = BASE + 20'($urandom_range(0, 11)); fill_ppn = 14'($urandom);
            end
            if (r >= 15 && r < 30) begin
                inval_valid = 1; inval_vpn = BASE + 20'($urandom_range(0, 11));
            end
            if (r >= 25 && r < 55) begin
                wopen_valid = 1; wopen_vpn = BASE + 20'($urandom_range(0, 11));
            end
            step("R9 random");
        end

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1;
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule